// File: doc/BRIEF.md
# DMA Read Request Splitter

This block sits between a DMA engine and a read-request path toward a serial link. The engine hands it one memory-read job, a start address and a byte length. The block turns that job into a stream of read-request descriptors. Each descriptor carries an address, a length and a tag. A descriptor never exceeds the request size chosen by a 3-bit power-of-two code, and it never spans a 4 KB address boundary.

Every descriptor claims a tag from a small pool. The tag stays claimed until the completion notifications for that tag add up to the requested length. Completions may arrive split into payload-sized pieces and in any order across tags. When every tag is claimed, the block stops issuing. Once the whole job has been issued and every tag is free again, the block pulses a done signal and accepts the next job.

Top module: `rd_req_splitter`

## Requirements
- R1: The size code selects the request limit as 128 bytes shifted left by the code for codes 0 to 5 (0 = 128, 3 = 1024, 5 = 4096). The reserved codes 6 and 7 act as 4096.
- R2: Every issued descriptor has a length of at least 1 byte and no more than the limit selected by the job's size code.
- R3: The descriptors of a job are contiguous and in ascending address order. The first starts at the job address, and their lengths sum to the job length. Each length is the smallest of the bytes left, the limit and the distance to the next 4 KB boundary, so the final one carries only the remainder.
- R4: No descriptor crosses a 4 KB boundary: the low 12 address bits plus the length never exceed 4096.
- R5: Each descriptor takes the lowest-numbered free tag at the time it is formed. A tag that is still pending is never handed out again.
- R6: While all NUM_TAGS tags are pending, no new descriptor is presented (req_valid stays low).
- R7: A tag is released only when the bytes reported by its completions reach its request length. A partial completion keeps it pending.
- R8: A completion that names a tag that is not pending is ignored.
- R9: job_done is a one-cycle pulse, raised in the same cycle job_busy falls. It occurs only after the last descriptor was accepted and every tag has been released.
- R10: job_start while job_busy is high is ignored. The address, length and size code are sampled only when a job is accepted.
- R11: While req_valid is high and req_ready is low, req_valid, req_addr, req_len and req_tag hold their values.
- R12: After reset, req_valid, job_busy and job_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_start | input | 1 | Job request; accepted when job_busy is low |
| job_addr | input | ADDR_W | Job start byte address |
| job_len | input | LEN_W | Job length in bytes |
| size_code | input | 3 | Request size code, sampled at job acceptance |
| job_busy | output | 1 | A job is in progress |
| job_done | output | 1 | One-cycle pulse when the job has fully finished |
| req_valid | output | 1 | Descriptor valid |
| req_ready | input | 1 | Downstream accepts the descriptor |
| req_addr | output | ADDR_W | Descriptor start address |
| req_len | output | 13 | Descriptor length in bytes (1 to 4096) |
| req_tag | output | TAG_W | Descriptor tag |
| cpl_valid | input | 1 | Completion notification valid |
| cpl_tag | input | TAG_W | Tag the completion belongs to |
| cpl_bytes | input | 13 | Bytes carried by this completion |

## Verification
An accepted job_start sets job_busy at the next edge. The first descriptor is registered one edge later. After a handshake edge, the next descriptor can appear at once, because loading and acceptance share that edge. A completion that releases a tag lets that tag be chosen for a descriptor at the edge after the release. job_done follows one edge after the release of the last tag.

The bench drives inputs and samples outputs on the falling edge. It records a handshake only when valid and ready are both high at that instant, so the transfer falls on the next rising edge. It updates its own tag model at the moment it drives a completion. Its expected address, length and tag are therefore already current when the next descriptor can be sampled.

// File: rtl/rrs_pkg.sv
// Shared constants and the size-code decode for the read request splitter.
// Assumes byte lengths of one request fit in 13 bits (at most 4096).
package rrs_pkg;
    localparam int CODE_W  = 3;
    localparam int BC_W    = 13;
    localparam int PAGE_SZ = 4096;
    localparam int MAX_CODE = 5;

    // Turns a size code into a byte limit; reserved codes clamp to 4096.
    function automatic logic [BC_W-1:0] size_from_code(input logic [CODE_W-1:0] c);
        if (int'(c) > MAX_CODE)
            return BC_W'(PAGE_SZ);
        else
            return BC_W'(128) << c;
    endfunction
endpackage

// File: rtl/rrs_size_decode.sv
// Size decoder: maps the held size code to a request byte limit.
// Assumes the code is stable for a whole job (held by the caller).
module rrs_size_decode
    import rrs_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [BC_W-1:0]   max_bytes
);
    // Pure decode of the power-of-two limit.
    always_comb max_bytes = size_from_code(code);
endmodule

// File: rtl/rrs_chunker.sv
// Chunk sizer: picks the length of the next descriptor as the smallest of
// bytes left, request limit and distance to the next 4 KB boundary.
// Assumes LEN_W >= BC_W and max_bytes in 1..4096.
module rrs_chunker
    import rrs_pkg::*;
#(
    parameter int LEN_W = 20
) (
    input  logic [11:0]      page_off,
    input  logic [LEN_W-1:0] remain,
    input  logic [BC_W-1:0]  max_bytes,
    output logic [BC_W-1:0]  chunk
);
    logic [BC_W-1:0] to_bnd;
    logic [BC_W-1:0] lim;

    // Distance to boundary, then clamp by limit and by bytes left.
    always_comb begin
        to_bnd = BC_W'(PAGE_SZ) - {1'b0, page_off};
        lim    = (max_bytes < to_bnd) ? max_bytes : to_bnd;
        if (remain < LEN_W'(lim))
            chunk = remain[BC_W-1:0];
        else
            chunk = lim;
    end
endmodule

// File: rtl/rrs_tag_pool.sv
// Tag pool: offers the lowest free tag, records the bytes still owed for
// each claimed tag, and frees a tag when its completions cover it.
// Assumes a claim and a completion never target the same tag in one cycle
// (claims only take free tags; completions to free tags are dropped).
module rrs_tag_pool
    import rrs_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [BC_W-1:0]  alloc_len,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [BC_W-1:0]  cpl_bytes,
    output logic [TAG_W-1:0] free_tag,
    output logic             any_free,
    output logic             all_idle
);
    logic [NUM_TAGS-1:0] busy_q;
    logic [BC_W-1:0]     owed_q [NUM_TAGS];

    // Lowest-index free tag search (downward scan so the lowest wins).
    always_comb begin
        free_tag = '0;
        any_free = 1'b0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                free_tag = TAG_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Pool fully drained flag.
    always_comb all_idle = ~|busy_q;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        // Per-tag claim / completion bookkeeping.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g] <= 1'b0;
                owed_q[g] <= '0;
            end else if (alloc_en && free_tag == TAG_W'(g)) begin
                busy_q[g] <= 1'b1;
                owed_q[g] <= alloc_len;
            end else if (cpl_valid && cpl_tag == TAG_W'(g) && busy_q[g]) begin
                if (cpl_bytes >= owed_q[g]) begin
                    busy_q[g] <= 1'b0;
                    owed_q[g] <= '0;
                end else begin
                    owed_q[g] <= owed_q[g] - cpl_bytes;
                end
            end
        end
    end
endmodule

// File: rtl/rd_req_splitter.sv
// Read request splitter top: accepts one job, emits registered descriptors
// (valid/ready), claims a tag per descriptor, and pulses done when the job
// is issued and all tags are back. Assumes completions only name tags whose
// descriptor was accepted; excess completion bytes simply free the tag.
module rd_req_splitter
    import rrs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 20,
    parameter int NUM_TAGS = 8,
    localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len,
    input  logic [2:0]        size_code,
    output logic              job_busy,
    output logic              job_done,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [12:0]       req_len,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [12:0]       cpl_bytes
);
    logic              busy_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [2:0]        code_q;

    logic              out_valid_q;
    logic [ADDR_W-1:0] out_addr_q;
    logic [BC_W-1:0]   out_len_q;
    logic [TAG_W-1:0]  out_tag_q;

    logic [BC_W-1:0]   max_bytes;
    logic [BC_W-1:0]   chunk;
    logic [TAG_W-1:0]  free_tag;
    logic              any_free;
    logic              all_idle;
    logic              can_load;
    logic              finish;

    rrs_size_decode u_dec (
        .code      (code_q),
        .max_bytes (max_bytes)
    );

    rrs_chunker #(.LEN_W(LEN_W)) u_chunk (
        .page_off  (addr_q[11:0]),
        .remain    (remain_q),
        .max_bytes (max_bytes),
        .chunk     (chunk)
    );

    rrs_tag_pool #(.NUM_TAGS(NUM_TAGS)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (can_load),
        .alloc_len (chunk),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .cpl_bytes (cpl_bytes),
        .free_tag  (free_tag),
        .any_free  (any_free),
        .all_idle  (all_idle)
    );

    // Next descriptor may be formed when work, a tag and an output slot exist.
    always_comb begin
        can_load = busy_q && (remain_q != '0) && any_free
                   && (!out_valid_q || req_ready);
        finish   = busy_q && (remain_q == '0) && !out_valid_q && all_idle;
    end

    // Job context: accept, advance by each formed chunk, and retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            addr_q   <= '0;
            remain_q <= '0;
            code_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (job_start) begin
                    busy_q   <= 1'b1;
                    addr_q   <= job_addr;
                    remain_q <= job_len;
                    code_q   <= size_code;
                end
            end else if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (can_load) begin
                addr_q   <= addr_q + ADDR_W'(chunk);
                remain_q <= remain_q - LEN_W'(chunk);
            end
        end
    end

    // Registered descriptor output with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_addr_q  <= '0;
            out_len_q   <= '0;
            out_tag_q   <= '0;
        end else if (can_load) begin
            out_valid_q <= 1'b1;
            out_addr_q  <= addr_q;
            out_len_q   <= chunk;
            out_tag_q   <= free_tag;
        end else if (req_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    // Port mapping of registered state.
    always_comb begin
        job_busy  = busy_q;
        job_done  = done_q;
        req_valid = out_valid_q;
        req_addr  = out_addr_q;
        req_len   = out_len_q;
        req_tag   = out_tag_q;
    end
endmodule

// File: rtl/rrs_checker.sv
// Property checker for the read request splitter, bound to the top module.
// Assumes it observes the held size code and the pool's free flag.
module rrs_checker #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [12:0]       req_len,
    input logic [TAG_W-1:0]  req_tag,
    input logic              job_done,
    input logic              job_busy,
    input logic [2:0]        code,
    input logic              pool_has_free
);
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != 13'd0 && req_len <= rrs_pkg::size_from_code(code))); // R2

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr[11:0]} + req_len <= 14'd4096)); // R4

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_len) && $stable(req_tag))); // R11

    AST_POOL_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pool_has_free && !req_valid) |=> !req_valid); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> (!job_busy && !req_valid)); // R9
endmodule

bind rd_req_splitter rrs_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_tag       (req_tag),
    .job_done      (job_done),
    .job_busy      (job_busy),
    .code          (code_q),
    .pool_has_free (any_free)
);

// File: tb/rd_req_splitter_test.sv
module rd_req_splitter_test;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 20;
    localparam int NT     = 8;
    localparam int TW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic job_start = 1'b0;
    logic [ADDR_W-1:0] job_addr = '0;
    logic [LEN_W-1:0]  job_len = '0;
    logic [2:0]        size_code = '0;
    logic job_busy, job_done, req_valid;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [12:0] req_len;
    logic [TW-1:0] req_tag;
    logic cpl_valid = 1'b0;
    logic [TW-1:0] cpl_tag = '0;
    logic [12:0] cpl_bytes = '0;

    always #4 clk = ~clk;

    rd_req_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_TAGS(NT)) uut (.*);

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // bench model
    logic [ADDR_W-1:0] exp_addr;
    int  exp_rem;
    int  exp_code;
    bit  pend [NT];
    int  owed [NT];
    bit  auto_rdy = 0, auto_cpl = 0, man_ready = 0;
    bit  man_cpl = 0;
    int  man_tag = 0, man_bytes = 0;
    int  hs_count = 0;
    int  last_tag = -1;
    bit  done_seen = 0;
    bit  hold = 0;
    logic [ADDR_W-1:0] h_addr;
    logic [12:0] h_len;
    logic [TW-1:0] h_tag;

    function automatic int dec(input int c);
        return (c > 5) ? 4096 : (128 << c);
    endfunction

    function automatic int exp_chunk(input logic [ADDR_W-1:0] a, input int rem, input int c);
        int lim = dec(c);
        int bnd = 4096 - int'(a[11:0]);
        if (bnd < lim) lim = bnd;
        return (rem < lim) ? rem : lim;
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < NT; i++) if (!pend[i]) return i;
        return -1;
    endfunction

    function automatic bit any_pend();
        for (int i = 0; i < NT; i++) if (pend[i]) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One falling-edge step: observe, then drive ready and completions.
    task automatic step();
        bit rdy;
        @(negedge clk);
        if (hold) begin
            check(req_valid == 1'b1, "R11 valid held", req_valid, 1);
            check(req_addr == h_addr && req_len == h_len && req_tag == h_tag,
                  "R11 descriptor held", req_addr, h_addr);
        end
        if (job_done) begin
            done_seen = 1;
            check(exp_rem == 0 && !any_pend(), "R9 done after all issued and freed",
                  exp_rem, 0);
            check(job_busy == 1'b0, "R9 busy falls with done", job_busy, 0);
        end
        // completion drive
        cpl_valid = 1'b0;
        if (man_cpl) begin
            man_cpl = 0;
            cpl_valid = 1'b1; cpl_tag = TW'(man_tag); cpl_bytes = 13'(man_bytes);
            if (pend[man_tag]) begin
                owed[man_tag] -= man_bytes;
                if (owed[man_tag] <= 0) pend[man_tag] = 0;
            end
        end else if (auto_cpl && ($urandom % 2 == 0)) begin
            int s = int'($urandom % NT);
            for (int k = 0; k < NT; k++) begin
                int t = (s + k) % NT;
                if (pend[t]) begin
                    int pay = 64 << ($urandom % 3);
                    int pc = (owed[t] < pay) ? owed[t] : pay;
                    cpl_valid = 1'b1; cpl_tag = TW'(t); cpl_bytes = 13'(pc);
                    owed[t] -= pc;
                    if (owed[t] == 0) pend[t] = 0;
                    break;
                end
            end
        end
        // ready drive and handshake record
        rdy = auto_rdy ? ($urandom % 4 != 0) : man_ready;
        req_ready = rdy;
        hold = req_valid && !rdy;
        h_addr = req_addr; h_len = req_len; h_tag = req_tag;
        if (req_valid && rdy) begin
            int ec = exp_chunk(exp_addr, exp_rem, exp_code);
            check(req_addr == exp_addr, "R3 address contiguous", req_addr, exp_addr);
            check(int'(req_len) == ec, "R1/R3/R4 length", req_len, ec);
            check(!pend[req_tag], "R5 tag not pending", req_tag, lowest_free());
            if (!auto_cpl)
                check(int'(req_tag) == lowest_free(), "R5 lowest free tag", req_tag, lowest_free());
            pend[req_tag] = 1;
            owed[req_tag] = int'(req_len);
            exp_addr = exp_addr + ADDR_W'(req_len);
            exp_rem -= int'(req_len);
            hs_count++;
            last_tag = int'(req_tag);
        end
    endtask

    task automatic start_job(input logic [ADDR_W-1:0] a, input int len, input int c);
        step();
        job_start = 1'b1; job_addr = a; job_len = LEN_W'(len); size_code = 3'(c);
        exp_addr = a; exp_rem = len; exp_code = c; done_seen = 0;
        step();
        job_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_seen && n < 30000) begin step(); n++; end
        check(done_seen, req, done_seen, 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NT; i++) begin pend[i] = 0; owed[i] = 0; end
        exp_rem = 0; exp_addr = '0; exp_code = 0;
        repeat (3) @(negedge clk);
        check(req_valid == 0 && job_busy == 0 && job_done == 0, "R12 reset state",
              {req_valid, job_busy, job_done}, 0);
        rst_n = 1'b1;

        // R6 / R5: fill every tag with completions held back
        man_ready = 1;
        start_job(32'h0, 128 * 12, 0);
        repeat (40) step();
        check(hs_count == NT, "R6 issues stop at pool size", hs_count, NT);
        check(req_valid == 0, "R6 no descriptor while pool full", req_valid, 0);

        // R7: partial completion keeps tag 2 pending
        man_tag = 2; man_bytes = 64; man_cpl = 1;
        repeat (10) step();
        check(hs_count == NT && req_valid == 0, "R7 partial completion keeps tag",
              hs_count, NT);
        man_tag = 2; man_bytes = 64; man_cpl = 1;
        repeat (10) step();
        check(hs_count == NT + 1, "R7 full completion frees tag", hs_count, NT + 1);
        check(last_tag == 2, "R5 freed tag 2 reused", last_tag, 2);

        auto_cpl = 1; auto_rdy = 1;
        wait_done("R9 done for directed job");

        // R8: stray completion to a free tag must not disturb the pool
        auto_cpl = 0; auto_rdy = 0; man_ready = 1;
        man_tag = 0; man_bytes = 100; man_cpl = 1;
        step();
        start_job(32'h0000_1F80, 200, 0);
        repeat (10) step();
        check(hs_count == NT + 1 + 3 + 2 || last_tag == 1, "R8 stray completion ignored",
              last_tag, 1);
        auto_cpl = 1; auto_rdy = 1;
        wait_done("R8 job completes after stray");

        // R1: every size code, including reserved ones
        for (int c = 0; c < 8; c++) begin
            start_job(32'h0001_0000, 9000, c);
            wait_done("R1 size code job");
        end

        // R10: second start while busy is ignored
        start_job(32'h0002_0040, 5000, 1);
        repeat (3) step();
        job_start = 1'b1; job_addr = 32'hDEAD_0000; job_len = 20'd7; size_code = 3'd7;
        step();
        job_start = 1'b0;
        wait_done("R10 busy start ignored");

        // R3/R4 random jobs with boundary-crossing addresses
        for (int j = 0; j < 30; j++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom % 32'h0010_0000);
            int len = 1 + int'($urandom % 20000);
            int c = int'($urandom % 8);
            if (j % 5 == 0) a[11:0] = 12'hFFF - 12'($urandom % 16);
            start_job(a, len, c);
            wait_done("R3 random job done");
        end

        // zero-length job retires without descriptors
        start_job(32'h100, 0, 2);
        wait_done("R9 zero-length job");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule